// File: doc/BRIEF.md
# Converter Start Sequencer

This block sits on the host side of a sampling analog-to-digital converter. It owns the converter's active-low start line and its reset line, and it watches the converter's busy output. The host asks for a conversion with a single-cycle request. The block then drives a start pulse and waits for busy to go high and then low. When the conversion ends it raises a one-cycle ready strobe, which tells a separate read engine that the result can be fetched.

All timing comes from nanosecond parameters and the system clock frequency. Each interval becomes a cycle count, rounded up, with a floor of one cycle. The block enforces a minimum start-pulse width, a minimum reset width, a minimum spacing between starts and an acquisition gap after each conversion. If busy never rises, or never falls, inside its expected window, the block reports a timeout. At most one request is held while the block is occupied, and requests beyond that one are counted as dropped.

The busy input is asynchronous. It passes through a two-stage synchroniser before edge detection, and the timeout windows include that extra latency.

Top module: `cnvstart_seq`

## Requirements
- R1: Each issued conversion drives `cnv_n` low for exactly CNV cycles, which is 1 at the 125 MHz default (ceil of 5 ns, at least one cycle). At all other times `cnv_n` is high.
- R2: Two successive falling edges of `cnv_n` are at least SPACE cycles apart, which is 250 by default (2 µs).
- R3: No new start falls earlier than ACQ cycles (94 by default, 750 ns rounded up) after the cycle in which `result_rdy` or `err_fall` is high.
- R4: `result_rdy` is high for exactly one cycle. It becomes visible after the third rising clock edge counted from the edge that first samples `busy_in` low.
- R5: If no rising edge of the synchronised busy appears within RISE cycles (10 by default) of the edge that starts the pulse, `err_rise` pulses for one cycle. The sequencer then goes idle without a ready strobe.
- R6: If busy stays high for CONV cycles (221 by default) after its rise is seen, `err_fall` pulses for one cycle and no ready strobe is given for that conversion.
- R7: A `reset_req` pulse drives `adc_rst` high for exactly RST cycles (2 by default, ceil of 10 ns). It aborts any conversion in progress, and the aborted conversion never raises `result_rdy`. `cnv_n` stays high while `adc_rst` is high.
- R8: Only one start request is held. A request that arrives while another is still pending and not being issued in that cycle adds one to `drop_cnt`. `drop_cnt` saturates at all ones, which is 255 for the 8-bit default.
- R9: During reset `cnv_n` is 1, `adc_rst` is 0, all three strobes are 0 and `drop_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Single-cycle conversion request |
| reset_req | input | 1 | Single-cycle request for a converter reset pulse |
| busy_in | input | 1 | Converter busy output, asynchronous |
| cnv_n | output | 1 | Active-low convert-start line to the converter |
| adc_rst | output | 1 | Active-high reset line to the converter |
| result_rdy | output | 1 | One-cycle strobe: conversion result can be read |
| err_rise | output | 1 | One-cycle strobe: busy never rose |
| err_fall | output | 1 | One-cycle strobe: busy stayed high too long |
| drop_cnt | output | DROP_W | Count of discarded start requests |

## Verification
The assertions assume that `busy_in` is at a defined level from reset onward and that `start_req` and `reset_req` are clean synchronous levels. The bench meets this by driving every input on the falling clock edge from a model of the converter. That model raises busy a few cycles after a start pulse and drops it after a programmed conversion length. It can also hold busy low forever or high forever. It also clears busy whenever `adc_rst` is high, as a real converter would. The stimulus covers isolated conversions, requests that arrive during a conversion, missing and stuck busy, resets during a conversion, and a long burst of requests that drives the drop counter to its ceiling.

// File: rtl/cnvstart_pkg.sv
package cnvstart_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_PULSE,
      ST_WRISE,
      ST_WFALL
   } seq_st_e;

   // Cycles covering a nanosecond interval at a clock in MHz, rounded up, at least one.
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
      int unsigned c;
      c = (ns * mhz + 999) / 1000;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cnvstart_sync.sv
module cnvstart_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);

   logic [STAGES:0] sh;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cnvstart_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign lvl  = sh[STAGES-1];
   assign rise =  sh[STAGES-1] & ~sh[STAGES];
   assign fall = ~sh[STAGES-1] &  sh[STAGES];

endmodule

// File: rtl/cnvstart_tmr.sv
module cnvstart_tmr #(
   parameter int unsigned LOAD_CYC = 4,
   localparam int unsigned W = $clog2(LOAD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= W'(LOAD_CYC - 1);
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/cnvstart_fsm.sv
module cnvstart_fsm
   import cnvstart_pkg::*;
#(
   parameter int unsigned RST_CYC  = 2,
   parameter int unsigned CNV_CYC  = 1,
   parameter int unsigned RISE_CYC = 10,
   parameter int unsigned CONV_CYC = 221
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reset_req,
   input  logic launch_ok,
   input  logic busy_rise,
   input  logic busy_fall,
   output logic issue,
   output logic acq_load,
   output logic cnv_n,
   output logic adc_rst,
   output logic result_rdy,
   output logic err_rise,
   output logic err_fall
);

   localparam int unsigned AGE_MAX = max2(max2(RST_CYC, CNV_CYC), max2(RISE_CYC, CONV_CYC));
   localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);
   localparam logic [AGE_W-1:0] RST_LAST  = AGE_W'(RST_CYC - 1);
   localparam logic [AGE_W-1:0] CNV_LAST  = AGE_W'(CNV_CYC - 1);
   localparam logic [AGE_W-1:0] RISE_LAST = AGE_W'(RISE_CYC - 1);
   localparam logic [AGE_W-1:0] CONV_LAST = AGE_W'(CONV_CYC - 1);

   seq_st_e          st;
   logic [AGE_W-1:0] age;
   logic             got_rise;
   logic             conv_over;

   assign conv_over = (age == CONV_LAST);
   assign issue     = (st == ST_IDLE) && !reset_req && launch_ok;
   assign acq_load  = (st == ST_WFALL) && !reset_req && (busy_fall || conv_over);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         age        <= '0;
         got_rise   <= 1'b0;
         result_rdy <= 1'b0;
         err_rise   <= 1'b0;
         err_fall   <= 1'b0;
      end else begin
         result_rdy <= 1'b0;
         err_rise   <= 1'b0;
         err_fall   <= 1'b0;
         if (reset_req && st != ST_RST) begin
            st  <= ST_RST;
            age <= '0;
         end else begin
            unique case (st)
               ST_IDLE: begin
                  if (launch_ok) begin
                     st       <= ST_PULSE;
                     age      <= '0;
                     got_rise <= 1'b0;
                  end
               end
               ST_RST: begin
                  if (age == RST_LAST) st <= ST_IDLE;
                  else                 age <= age + AGE_W'(1);
               end
               ST_PULSE: begin
                  if (busy_rise)         got_rise <= 1'b1;
                  if (age == CNV_LAST)   st <= ST_WRISE;
                  age <= age + AGE_W'(1);
               end
               ST_WRISE: begin
                  if (got_rise || busy_rise) begin
                     st  <= ST_WFALL;
                     age <= '0;
                  end else if (age == RISE_LAST) begin
                     err_rise <= 1'b1;
                     st       <= ST_IDLE;
                  end else begin
                     age <= age + AGE_W'(1);
                  end
               end
               ST_WFALL: begin
                  if (busy_fall) begin
                     result_rdy <= 1'b1;
                     st         <= ST_IDLE;
                  end else if (conv_over) begin
                     err_fall <= 1'b1;
                     st       <= ST_IDLE;
                  end else begin
                     age <= age + AGE_W'(1);
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign cnv_n   = (st != ST_PULSE);
   assign adc_rst = (st == ST_RST);

endmodule

// File: rtl/cnvstart_seq.sv
module cnvstart_seq
   import cnvstart_pkg::*;
#(
   parameter int unsigned CLK_MHZ         = 125,
   parameter int unsigned CNV_LOW_NS      = 5,
   parameter int unsigned SPACING_NS      = 2000,
   parameter int unsigned RISE_MAX_NS     = 30,
   parameter int unsigned RISE_MARGIN_CYC = 4,
   parameter int unsigned CONV_NS         = 1250,
   parameter int unsigned CONV_MARGIN_NS  = 500,
   parameter int unsigned ACQ_NS          = 750,
   parameter int unsigned RST_NS          = 10,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned DROP_W          = 8,
   parameter bit          DROP_SAT        = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic              reset_req,
   input  logic              busy_in,
   output logic              cnv_n,
   output logic              adc_rst,
   output logic              result_rdy,
   output logic              err_rise,
   output logic              err_fall,
   output logic [DROP_W-1:0] drop_cnt
);

   localparam int unsigned CNV_CYC   = ns_to_cyc(CNV_LOW_NS, CLK_MHZ);
   localparam int unsigned SPACE_CYC = ns_to_cyc(SPACING_NS, CLK_MHZ);
   localparam int unsigned ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_MHZ);
   localparam int unsigned RST_CYC   = ns_to_cyc(RST_NS, CLK_MHZ);
   localparam int unsigned RISE_CYC  = ns_to_cyc(RISE_MAX_NS, CLK_MHZ) + SYNC_STAGES + RISE_MARGIN_CYC;
   localparam int unsigned CONV_CYC  = ns_to_cyc(CONV_NS + CONV_MARGIN_NS, CLK_MHZ) + SYNC_STAGES;

   generate
      if (RISE_CYC <= CNV_CYC) begin : g_bad_rise
         $error("cnvstart_seq: rise window must outlast the start pulse");
      end
      if (DROP_W < 1) begin : g_bad_drop
         $error("cnvstart_seq: DROP_W must be at least 1");
      end
      if (CLK_MHZ == 0) begin : g_bad_clk
         $error("cnvstart_seq: CLK_MHZ must be non-zero");
      end
   endgenerate

   logic busy_lvl, busy_rise, busy_fall;
   logic space_zero, acq_zero;
   logic issue, acq_load, launch_ok;
   logic pend, drop_evt;

   cnvstart_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (busy_in),
      .lvl  (busy_lvl),
      .rise (busy_rise),
      .fall (busy_fall)
   );

   cnvstart_tmr #(.LOAD_CYC(SPACE_CYC)) u_space (
      .clk  (clk),
      .rst_n(rst_n),
      .load (issue),
      .zero (space_zero)
   );

   cnvstart_tmr #(.LOAD_CYC(ACQ_CYC)) u_acq (
      .clk  (clk),
      .rst_n(rst_n),
      .load (acq_load),
      .zero (acq_zero)
   );

   assign launch_ok = pend & space_zero & acq_zero;

   cnvstart_fsm #(
      .RST_CYC (RST_CYC),
      .CNV_CYC (CNV_CYC),
      .RISE_CYC(RISE_CYC),
      .CONV_CYC(CONV_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .reset_req (reset_req),
      .launch_ok (launch_ok),
      .busy_rise (busy_rise),
      .busy_fall (busy_fall),
      .issue     (issue),
      .acq_load  (acq_load),
      .cnv_n     (cnv_n),
      .adc_rst   (adc_rst),
      .result_rdy(result_rdy),
      .err_rise  (err_rise),
      .err_fall  (err_fall)
   );

   // Single-entry request holder
   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= (pend & ~issue) | start_req;
   end

   assign drop_evt = start_req & pend & ~issue;

   logic [DROP_W-1:0] drop_q;

   generate
      if (DROP_SAT) begin : g_drop_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                         drop_q <= '0;
            else if (drop_evt && drop_q != '1)  drop_q <= drop_q + DROP_W'(1);
         end
      end else begin : g_drop_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)        drop_q <= '0;
            else if (drop_evt) drop_q <= drop_q + DROP_W'(1);
         end
      end
   endgenerate

   assign drop_cnt = drop_q;

endmodule

// File: rtl/cnvstart_chk.sv
module cnvstart_chk #(
   parameter int unsigned CNV_CYC   = 1,
   parameter int unsigned SPACE_CYC = 250,
   parameter int unsigned RST_CYC   = 2,
   parameter int unsigned DROP_W    = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnv_n,
   input logic              adc_rst,
   input logic              result_rdy,
   input logic              err_rise,
   input logic              err_fall,
   input logic              busy_fall,
   input logic [DROP_W-1:0] drop_cnt
);

   localparam int unsigned GW = $clog2(SPACE_CYC + 2);

   logic [GW-1:0] lo_run, rst_run, gap;
   logic          cnv_q, armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_run  <= '0;
         rst_run <= '0;
         gap     <= '0;
         cnv_q   <= 1'b1;
         armed   <= 1'b0;
      end else begin
         cnv_q   <= cnv_n;
         lo_run  <= cnv_n   ? '0 : lo_run + GW'(1);
         rst_run <= adc_rst ? rst_run + GW'(1) : '0;
         if (cnv_q && !cnv_n) begin
            gap   <= GW'(1);
            armed <= 1'b1;
         end else if (gap < GW'(SPACE_CYC)) begin
            gap <= gap + GW'(1);
         end
      end
   end

   p_pulse_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_n) |-> lo_run == GW'(CNV_CYC));

   p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cnv_n) && armed) |-> gap >= GW'(SPACE_CYC));

   p_rdy_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      result_rdy |-> $past(busy_fall));

   p_rdy_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      result_rdy |=> !result_rdy);

   p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({result_rdy, err_rise, err_fall}));

   p_rst_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rst) |-> rst_run == GW'(RST_CYC));

   p_rst_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      adc_rst |-> cnv_n);

   p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt) |-> drop_cnt == $past(drop_cnt) + DROP_W'(1));

endmodule

bind cnvstart_seq cnvstart_chk #(
   .CNV_CYC  (CNV_CYC),
   .SPACE_CYC(SPACE_CYC),
   .RST_CYC  (RST_CYC),
   .DROP_W   (DROP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnv_n     (cnv_n),
   .adc_rst   (adc_rst),
   .result_rdy(result_rdy),
   .err_rise  (err_rise),
   .err_fall  (err_fall),
   .busy_fall (busy_fall),
   .drop_cnt  (drop_cnt)
);

// File: tb/cnvstart_seq_bench.sv
module cnvstart_seq_bench;

   // Expected cycle counts at 125 MHz, taken from the requirements
   localparam int E_CNV  = 1;    // R1
   localparam int E_SPC  = 250;  // R2
   localparam int E_ACQ  = 94;   // R3
   localparam int E_RISE = 10;   // R5
   localparam int E_CONV = 221;  // R6
   localparam int E_RST  = 2;    // R7
   localparam int E_DMAX = 255;  // R8

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0;
   logic       reset_req = 1'b0;
   logic       busy_in = 1'b0;
   logic       cnv_n, adc_rst, result_rdy, err_rise, err_fall;
   logic [7:0] drop_cnt;

   always #4 clk = ~clk;

   cnvstart_seq u_cnvstart_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .reset_req (reset_req),
      .busy_in   (busy_in),
      .cnv_n     (cnv_n),
      .adc_rst   (adc_rst),
      .result_rdy(result_rdy),
      .err_rise  (err_rise),
      .err_fall  (err_fall),
      .drop_cnt  (drop_cnt)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_ph;       // 0 idle, 1 reset pulse, 2 start pulse, 3 wait rise, 4 wait fall
   int m_age, m_spc, m_acq, m_drop;
   bit m_pend, m_gr, m_rdy, m_er, m_ef;
   bit h0, h1, h2;

   always @(posedge clk) begin
      bit rise, fall, go, ld;
      if (!rst_n) begin
         m_ph = 0; m_age = 0; m_spc = 0; m_acq = 0; m_drop = 0;
         m_pend = 0; m_gr = 0; m_rdy = 0; m_er = 0; m_ef = 0;
         h0 = 0; h1 = 0; h2 = 0;
      end else begin
         rise  = h1 && !h2;
         fall  = !h1 && h2;
         m_rdy = 0; m_er = 0; m_ef = 0;
         go = (m_ph == 0) && !reset_req && m_pend && m_spc == 0 && m_acq == 0;
         ld = 0;
         if (reset_req && m_ph != 1) begin
            m_ph = 1; m_age = 0;
         end else begin
            case (m_ph)
               0: if (go) begin m_ph = 2; m_age = 0; m_gr = 0; end
               1: if (m_age == E_RST - 1) m_ph = 0; else m_age++;
               2: begin
                  if (rise) m_gr = 1;
                  if (m_age == E_CNV - 1) m_ph = 3;
                  m_age++;
               end
               3: if (m_gr || rise) begin m_ph = 4; m_age = 0; end
                  else if (m_age == E_RISE - 1) begin m_er = 1; m_ph = 0; end
                  else m_age++;
               4: if (fall) begin m_rdy = 1; m_ph = 0; ld = 1; end
                  else if (m_age == E_CONV - 1) begin m_ef = 1; m_ph = 0; ld = 1; end
                  else m_age++;
               default: m_ph = 0;
            endcase
         end
         if (go) m_spc = E_SPC - 1; else if (m_spc > 0) m_spc--;
         if (ld) m_acq = E_ACQ - 1; else if (m_acq > 0) m_acq--;
         if (start_req && m_pend && !go && m_drop < E_DMAX) m_drop++;
         m_pend = (m_pend && !go) || start_req;
         h2 = h1; h1 = h0; h0 = busy_in;
      end
   end

   // ---------------- per-cycle comparison and measurements ----------------
   int cyc = 0;
   int lo_run = 0, rst_run = 0;
   int last_fall = -1, last_end = -1, bfall = -1;
   int n_rdy = 0, n_er = 0, n_ef = 0;
   bit p_cnv = 1'b1, p_busy = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check(cnv_n == (m_ph != 2), "R1 cnv_n", cnv_n, m_ph != 2);
         check(adc_rst == (m_ph == 1), "R7 adc_rst", adc_rst, m_ph == 1);
         check(result_rdy == m_rdy, "R4 result_rdy", result_rdy, m_rdy);
         check(err_rise == m_er, "R5 err_rise", err_rise, m_er);
         check(err_fall == m_ef, "R6 err_fall", err_fall, m_ef);
         check(drop_cnt == 8'(m_drop), "R8 drop_cnt", drop_cnt, m_drop);

         if (!cnv_n) lo_run++;
         else if (lo_run > 0) begin
            check(lo_run == E_CNV, "R1 pulse width", lo_run, E_CNV);
            lo_run = 0;
         end
         if (adc_rst) rst_run++;
         else if (rst_run > 0) begin
            check(rst_run == E_RST, "R7 reset width", rst_run, E_RST);
            rst_run = 0;
         end
         if (p_cnv && !cnv_n) begin
            if (last_fall >= 0)
               check(cyc - last_fall >= E_SPC, "R2 spacing", cyc - last_fall, E_SPC);
            if (last_end > last_fall && last_fall >= 0)
               check(cyc - last_end >= E_ACQ, "R3 acquisition", cyc - last_end, E_ACQ);
            last_fall = cyc;
         end
         if (p_busy && !busy_in) bfall = cyc;
         if (result_rdy) begin
            n_rdy++;
            last_end = cyc;
            check(cyc - bfall == 2, "R4 ready latency", cyc - bfall, 2);
         end
         if (err_fall) begin n_ef++; last_end = cyc; end
         if (err_rise) n_er++;
      end
      p_cnv  = cnv_n;
      p_busy = busy_in;
   end

   // ---------------- converter model ----------------
   int  cfg_rise = 2;
   int  cfg_len  = 156;
   int  a_st = 0, a_cnt = 0;
   bit  a_prev = 1'b1;

   always @(negedge clk) begin
      if (!rst_n || adc_rst) begin
         a_st = 0;
         busy_in <= 1'b0;
      end else begin
         case (a_st)
            0: if (a_prev && !cnv_n && cfg_rise >= 0) begin a_st = 1; a_cnt = cfg_rise; end
            1: if (a_cnt == 0) begin busy_in <= 1'b1; a_st = 2; a_cnt = cfg_len; end
               else a_cnt--;
            2: if (a_cnt == 0) begin busy_in <= 1'b0; a_st = 0; end
               else a_cnt--;
            default: a_st = 0;
         endcase
      end
      a_prev = cnv_n;
   end

   // ---------------- stimulus ----------------
   task automatic pulse_start();
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
   endtask

   task automatic pulse_reset();
      @(negedge clk) reset_req = 1'b1;
      @(negedge clk) reset_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int r0;
      idle(3);
      check(cnv_n == 1'b1, "R9 reset cnv_n", cnv_n, 1);
      check(adc_rst == 1'b0, "R9 reset adc_rst", adc_rst, 0);
      check({result_rdy, err_rise, err_fall} == 3'b000, "R9 reset strobes",
            {result_rdy, err_rise, err_fall}, 0);
      check(drop_cnt == 8'd0, "R9 reset drop_cnt", drop_cnt, 0);
      @(negedge clk) rst_n = 1'b1;
      idle(5);

      // isolated conversion
      pulse_start();
      idle(400);
      check(n_rdy == 1, "R4 one ready per conversion", n_rdy, 1);

      // request during conversion held, third one dropped
      pulse_start();
      idle(10);
      pulse_start();
      pulse_start();
      idle(800);
      check(n_rdy == 3, "R8 held request served", n_rdy, 3);
      check(drop_cnt == 8'd1, "R8 extra request dropped", drop_cnt, 1);

      // busy never rises
      cfg_rise = -1;
      pulse_start();
      idle(300);
      check(n_er == 1, "R5 rise timeout", n_er, 1);
      check(n_rdy == 3, "R5 no ready on rise timeout", n_rdy, 3);

      // busy stuck high
      cfg_rise = 2;
      cfg_len  = 100000;
      pulse_start();
      idle(300);
      check(n_ef == 1, "R6 fall timeout", n_ef, 1);
      check(n_rdy == 3, "R6 no ready on fall timeout", n_rdy, 3);
      pulse_reset();
      idle(20);

      // reset during a conversion
      cfg_len = 156;
      idle(300);
      r0 = n_rdy;
      pulse_start();
      idle(60);
      pulse_reset();
      idle(400);
      check(n_rdy == r0, "R7 aborted conversion gives no ready", n_rdy, r0);

      // burst of requests: drop counter saturates
      cfg_len = 100000;
      @(negedge clk) start_req = 1'b1;
      idle(320);
      @(negedge clk) start_req = 1'b0;
      check(drop_cnt == 8'(E_DMAX), "R8 drop saturation", drop_cnt, E_DMAX);
      idle(300);
      pulse_reset();
      cfg_len = 156;
      idle(400);

      // normal operation after recovery
      r0 = n_rdy;
      pulse_start();
      idle(400);
      check(n_rdy == r0 + 1, "R4 ready after recovery", n_rdy, r0 + 1);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      finish_run();
   end

endmodule